// File: doc/BRIEF.md
# Paged Serial EEPROM Target Model

This block is a synthesizable two-wire bus target that behaves like a 2048-byte serial EEPROM split into eight banks of 256 bytes. A controller opens a transaction with a start condition and a control byte holding a fixed device code, a three-bit bank number and a direction bit. In write direction the next byte sets the low eight address bits, and every byte after that is stored. The address pointer advances only inside a 16-byte page, so a long write folds back to the start of its page instead of spilling into the next one.

Reading uses the usual random-read sequence. The controller sends a write-direction control byte and a low address, then a repeated start and a read-direction control byte. The target then returns bytes from consecutive addresses until the controller answers a byte with a not-acknowledge. During sequential reads the whole 11-bit address advances and rolls over from the last byte of the array to byte zero.

The bus lines are oversampled by the system clock. SDA is modelled as open-drain: `sda_o` is always low, and `sda_oe` pulls the line. While `busy_i` is high the target refuses its control byte.

Top module: `pwee_target`

## Requirements
- R1: A control byte is accepted only when bits 7:4 equal 4'b1010. Bits 3:1 then give the bank (address bits 10:8) and bit 0 gives the direction, where 1 means read. A byte with any other code gets no acknowledge, and the bytes that follow it until the next start change nothing.
- R2: After each byte it accepts (control, low address or write data), the target pulls SDA low for the whole ninth SCL clock, so the controller samples 0 there.
- R3: If `busy_i` is high when the eighth bit of the control byte completes, the target does not acknowledge, and any bytes that follow up to the next start leave the memory unchanged.
- R4: Write data bytes go to {bank, low address} and onward. After each stored byte only address bits 3:0 advance, wrapping modulo 16, so bits 10:4 stay fixed for the whole write.
- R5: A write-direction control byte plus a low address, then a repeated start and a read-direction control byte, returns the byte stored at {bank, low address}, most significant bit first.
- R6: Each further read byte that the controller acknowledges comes from the next address, counted over all 11 bits, so address 0x7FF is followed by 0x000.
- R7: When the controller answers a read byte with a not-acknowledge (SDA high on the ninth clock), the target releases SDA and keeps it released on any further clocks until the next start.
- R8: While reset is high, and on the first clock after it, `sda_oe` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus lines |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| busy_i | input | 1 | High to make the target refuse its control byte |
| sda_o | output | 1 | Value driven onto SDA when enabled (always 0) |
| sda_oe | output | 1 | High to pull SDA low |

## Verification
A corrupted bit counter or state shows up as an acknowledge in the wrong slot or no acknowledge at all. The controller sees this on the very next ninth clock. A wrong address register does not show up during the write itself; it appears only when the affected bytes are read back, one transaction later. Page-wrap and array-wrap mistakes are therefore caught by reading a whole page from its base and by reading across 0x7FF. A wrong bit order or a stuck read shifter corrupts the first returned byte.

// File: rtl/pwee_pkg.sv
package pwee_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,  // waiting for a start
    ST_CTRL,  // shifting in the control byte
    ST_ACKC,  // acknowledging the control byte
    ST_ADDR,  // shifting in the low address
    ST_ACKA,  // acknowledging the low address
    ST_WR,    // shifting in a data byte
    ST_ACKW,  // acknowledging a data byte
    ST_RD,    // shifting out a data byte
    ST_RACK   // sampling the controller's acknowledge
  } tgt_state_t;
endpackage

// File: rtl/pwee_line_sync.sv
module pwee_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_p, sda_p;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= '1;
      sda_p <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_p <= {scl_p[STAGES-2:0], scl_i};
      sda_p <= {sda_p[STAGES-2:0], sda_i};
      scl_d <= scl_p[STAGES-1];
      sda_d <= sda_p[STAGES-1];
    end
  end

  assign scl_s    = scl_p[STAGES-1];
  assign sda_s    = sda_p[STAGES-1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  // data edges while the clock stays high mark start and stop
  assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/pwee_addr_ctr.sv
module pwee_addr_ctr #(
  parameter int BANK_BITS = 3,
  parameter int LOW_BITS  = 8,
  parameter int PAGE_BITS = 4,
  localparam int AW = BANK_BITS + LOW_BITS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 set_bank,
  input  logic [BANK_BITS-1:0] bank_in,
  input  logic                 set_low,
  input  logic [LOW_BITS-1:0]  low_in,
  input  logic                 step_page,
  input  logic                 step_seq,
  output logic [AW-1:0]        addr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
    end else begin
      if (set_bank) addr[AW-1:LOW_BITS] <= bank_in;
      if (set_low)  addr[LOW_BITS-1:0]  <= low_in;
      if (step_page)
        addr[PAGE_BITS-1:0] <= addr[PAGE_BITS-1:0] + 1'b1;
      else if (step_seq)
        addr <= addr + 1'b1;
    end
  end
endmodule

// File: rtl/pwee_store.sv
module pwee_store #(
  parameter int AW     = 11,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/pwee_target.sv
module pwee_target
  import pwee_pkg::*;
#(
  parameter int         BANK_BITS   = 3,
  parameter int         LOW_BITS    = 8,
  parameter int         PAGE_BITS   = 4,
  parameter logic [3:0] DEV_CODE    = 4'b1010,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  input  logic busy_i,
  output logic sda_o,
  output logic sda_oe
);
  localparam int ADDR_W = BANK_BITS + LOW_BITS;

  logic sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  tgt_state_t state;
  logic [3:0] bit_cnt;
  logic [7:0] rx_sh, tx_sh, rdata;
  logic rd_mode, mack;
  logic [ADDR_W-1:0] addr;
  logic byte_done, code_hit, take_ctrl, set_low, mem_we, step_seq;

  pwee_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  assign byte_done = scl_fall && (bit_cnt == 4'd8);
  assign code_hit  = (rx_sh[7:4] == DEV_CODE);
  assign take_ctrl = (state == ST_CTRL) && byte_done && code_hit && !busy_i;
  assign set_low   = (state == ST_ADDR) && byte_done;
  assign mem_we    = (state == ST_WR) && byte_done;
  assign step_seq  = (state == ST_RD) && byte_done;

  pwee_addr_ctr #(
    .BANK_BITS(BANK_BITS), .LOW_BITS(LOW_BITS), .PAGE_BITS(PAGE_BITS)
  ) u_addr (
    .clk(clk), .rst(rst),
    .set_bank(take_ctrl), .bank_in(rx_sh[BANK_BITS:1]),
    .set_low(set_low), .low_in(rx_sh[LOW_BITS-1:0]),
    .step_page(mem_we), .step_seq(step_seq),
    .addr(addr)
  );

  pwee_store #(.AW(ADDR_W), .DATA_W(8)) u_mem (
    .clk(clk), .we(mem_we), .addr(addr), .wdata(rx_sh), .rdata(rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      rd_mode <= 1'b0;
      mack    <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (start_ev) begin
      state   <= ST_CTRL;
      bit_cnt <= '0;
      sda_oe  <= 1'b0;
    end else if (stop_ev) begin
      state   <= ST_IDLE;
      sda_oe  <= 1'b0;
    end else begin
      case (state)
        ST_CTRL, ST_ADDR, ST_WR: begin
          if (scl_rise) begin
            rx_sh   <= {rx_sh[6:0], sda_s};
            bit_cnt <= bit_cnt + 1'b1;
          end
          if (byte_done) begin
            bit_cnt <= '0;
            if (state == ST_CTRL) begin
              if (take_ctrl) begin
                sda_oe  <= 1'b1;
                rd_mode <= rx_sh[0];
                state   <= ST_ACKC;
              end else begin
                state   <= ST_IDLE;
              end
            end else begin
              sda_oe <= 1'b1;
              state  <= (state == ST_ADDR) ? ST_ACKA : ST_ACKW;
            end
          end
        end
        ST_ACKC: begin
          if (scl_fall) begin
            bit_cnt <= '0;
            if (rd_mode) begin
              tx_sh  <= rdata;
              sda_oe <= ~rdata[7];
              state  <= ST_RD;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_ADDR;
            end
          end
        end
        ST_ACKA, ST_ACKW: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            state  <= ST_WR;
          end
        end
        ST_RD: begin
          if (scl_rise) bit_cnt <= bit_cnt + 1'b1;
          if (scl_fall) begin
            if (bit_cnt == 4'd8) begin
              sda_oe <= 1'b0;
              state  <= ST_RACK;
            end else begin
              tx_sh  <= {tx_sh[6:0], 1'b0};
              sda_oe <= ~tx_sh[6];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) mack <= ~sda_s;
          if (scl_fall) begin
            if (mack) begin
              tx_sh   <= rdata;
              sda_oe  <= ~rdata[7];
              bit_cnt <= '0;
              state   <= ST_RD;
            end else begin
              state   <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_o = 1'b0;
endmodule

// File: rtl/pwee_target_chk.sv
module pwee_target_chk
  import pwee_pkg::*;
#(
  parameter int AW   = 11,
  parameter int PAGE = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       scl_i,
  input logic       busy_i,
  input logic       sda_oe,
  input tgt_state_t state,
  input logic [AW-1:0] addr,
  input logic       step_page,
  input logic       step_seq
);
  // R8: line released right after reset
  a_r8_release_after_reset: assert property (@(posedge clk)
    $past(rst) |-> !sda_oe);

  // R2 / R5: the target only moves SDA while SCL is low
  a_r2_oe_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_i);

  // R3: busy at the control decision never leads to an acknowledge
  a_r3_busy_no_ack: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CTRL && busy_i) |=> state != ST_ACKC);

  // R4: a page step keeps the upper address bits
  a_r4_page_kept: assert property (@(posedge clk) disable iff (rst)
    step_page |=> addr[AW-1:PAGE] == $past(addr[AW-1:PAGE]));

  // R6: a sequential step adds one over the full width
  a_r6_seq_step: assert property (@(posedge clk) disable iff (rst)
    step_seq |=> addr == AW'($past(addr) + 1'b1));
endmodule

bind pwee_target pwee_target_chk #(.AW(ADDR_W), .PAGE(PAGE_BITS)) u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .busy_i(busy_i), .sda_oe(sda_oe),
  .state(state), .addr(addr), .step_page(mem_we), .step_seq(step_seq)
);

// File: tb/sim_pwee_target.sv
`timescale 1ns/1ps
module sim_pwee_target;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_scl = 1'b1, host_sda = 1'b1, busy = 1'b0;
  logic sda_o, sda_oe, bus;
  int tests = 0, fails = 0;
  bit done = 0;

  logic [7:0] mdl [2048];
  bit         mval [2048];

  always #5 clk = ~clk;
  assign bus = host_sda & ~sda_oe;

  pwee_target u0 (
    .clk(clk), .rst(rst), .scl_i(host_scl), .sda_i(bus),
    .busy_i(busy), .sda_o(sda_o), .sda_oe(sda_oe)
  );

  // fields: [26:24] bank, [23:16] low address, [12:8] count, [7:0] seed
  localparam logic [31:0] VEC [6] = '{
    {5'd0, 3'd0, 8'h00, 3'd0, 5'd8,  8'h11},
    {5'd0, 3'd2, 8'h40, 3'd0, 5'd16, 8'h30},
    {5'd0, 3'd7, 8'hF0, 3'd0, 5'd4,  8'hA0},
    {5'd0, 3'd5, 8'h0D, 3'd0, 5'd6,  8'h50},
    {5'd0, 3'd3, 8'h2F, 3'd0, 5'd1,  8'h77},
    {5'd0, 3'd1, 8'h80, 3'd0, 5'd3,  8'hC3}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bit_out(input logic b);
    host_scl = 0; tick(5); host_sda = b; tick(5);
    host_scl = 1; tick(10);
  endtask

  task automatic bit_in(output logic r);
    host_scl = 0; tick(5); host_sda = 1; tick(5);
    host_scl = 1; tick(5); r = bus; tick(5);
  endtask

  task automatic bus_start;
    host_scl = 0; tick(5); host_sda = 1; tick(5);
    host_scl = 1; tick(5); host_sda = 0; tick(5);
  endtask

  task automatic bus_stop;
    host_scl = 0; tick(5); host_sda = 0; tick(5);
    host_scl = 1; tick(5); host_sda = 1; tick(5);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic r;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(r);
    acked = ~r;
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic nack);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bit_in(r);
      d[i] = r;
    end
    bit_out(nack);
  endtask

  task automatic write_txn(input logic [2:0] bank, input logic [7:0] low,
                           input int cnt, input logic [7:0] seed);
    logic a;
    logic [10:0] wa;
    bus_start;
    send_byte({4'b1010, bank, 1'b0}, a); chk("R2 control ack", a, 1);
    send_byte(low, a);                    chk("R2 address ack", a, 1);
    for (int i = 0; i < cnt; i++) begin
      send_byte(seed + 8'(i), a);         chk("R2 data ack", a, 1);
      wa = {bank, low[7:4], 4'(low[3:0] + 4'(i))};
      mdl[wa] = seed + 8'(i);
      mval[wa] = 1;
    end
    bus_stop;
  endtask

  task automatic read_txn(input logic [2:0] bank, input logic [7:0] low,
                          input int cnt, input string req);
    logic a;
    logic [7:0] d;
    logic [10:0] ra;
    bus_start;
    send_byte({4'b1010, bank, 1'b0}, a); chk("R2 control ack", a, 1);
    send_byte(low, a);                    chk("R2 address ack", a, 1);
    bus_start;
    send_byte({4'b1010, bank, 1'b1}, a); chk("R5 read control ack", a, 1);
    for (int i = 0; i < cnt; i++) begin
      recv_byte(d, i == cnt - 1);
      ra = 11'({bank, low} + i);
      if (mval[ra]) chk(req, d, mdl[ra]);
    end
    bus_stop;
  endtask

  initial begin
    logic a, r;
    logic [7:0] d;
    for (int i = 0; i < 2048; i++) begin
      mdl[i] = 8'h00;
      mval[i] = 0;
    end
    tick(2);
    chk("R8 oe during reset", sda_oe, 0);
    tick(3);
    rst = 0;
    tick(1);
    chk("R8 oe after reset", sda_oe, 0);
    tick(10);

    // table walk: write, then read the whole page from its base (R4 R5 R6)
    for (int k = 0; k < 6; k++) begin
      write_txn(VEC[k][26:24], VEC[k][23:16], int'(VEC[k][12:8]), VEC[k][7:0]);
      read_txn(VEC[k][26:24], {VEC[k][23:20], 4'h0}, 16, "R4 R5 page readback");
    end

    // R4: wrapped write landed at page offsets 0..2 of bank 5, page 0
    read_txn(3'd5, 8'h00, 3, "R4 wrap to page base");

    // R1: wrong device code is not acknowledged and its bytes are ignored
    bus_start;
    send_byte(8'b1011_0000, a); chk("R1 wrong code no ack", a, 0);
    send_byte(8'h00, a);
    send_byte(8'hEE, a);
    bus_stop;
    read_txn(3'd0, 8'h00, 1, "R1 ignored write left data");

    // R1: bank bits select a distinct bank
    write_txn(3'd6, 8'h00, 1, 8'h5A);
    read_txn(3'd0, 8'h00, 1, "R1 bank 0 untouched");
    read_txn(3'd6, 8'h00, 1, "R1 bank 6 data");

    // R3: busy refuses the control byte, data is not stored
    busy = 1;
    bus_start;
    send_byte(8'b1010_0000, a); chk("R3 busy no ack", a, 0);
    send_byte(8'h01, a);
    send_byte(8'hEE, a);
    bus_stop;
    busy = 0;
    read_txn(3'd0, 8'h01, 1, "R3 busy write ignored");

    // R6: sequential read rolls over from 0x7FF to 0x000
    write_txn(3'd7, 8'hFE, 2, 8'h90);
    read_txn(3'd7, 8'hFE, 4, "R6 array wrap");

    // R7: after a not-acknowledge the line stays released
    bus_start;
    send_byte(8'b1010_0000, a);
    send_byte(8'h00, a);
    bus_start;
    send_byte(8'b1010_0001, a);
    recv_byte(d, 1'b1);
    chk("R5 first read byte msb first", d, 8'h11);
    bit_in(r); chk("R7 released after nack", r, 1);
    bit_in(r); chk("R7 still released", r, 1);
    bus_stop;

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule